// File: doc/BRIEF.md
# Peripheral Core Run-State Controller

This block sits in front of a serial peripheral core and decides whether that core is held in reset, running, or paused. Software programs it through a small register port. A 2-bit state request is written into the state register. The controller then withdraws its state-valid flag and waits a fixed settling window. After that it applies the new state and raises valid again. Software is expected to poll the flag back to 1 before it issues another request. A request of value 2 performs no state change. It only flushes the data path.

The controller also keeps the core configuration word: the mini-core select, the input and output disables, and the word length. It drives these to the shifter as separate fields. The word can be changed only while the core is held in reset.

A separate software-reset register returns every register in the block to its power-on value. It then holds valid low for a longer settling window, during which the flush output stays asserted. The run, pause and flush outputs steer the FIFOs and the shifter that sit outside this block.

Top module: `core_runstate_ctrl`

## Requirements
- R1: After reset the state register reads 0x4 (state code 0 = reset in bits 1:0, valid = 1 in bit 2), the configuration register reads 0, and core_run, core_pause and core_flush are all 0.
- R2: A write to the state register (address 1) while valid is 1 makes valid read 0 for exactly SETTLE_CYCLES cycles after the write edge. Valid then returns to 1 with the requested code in bits 1:0. Code 1 drives core_run and code 3 drives core_pause, and the two are never high together.
- R3: While valid is 0, the state code, core_run and core_pause keep their previous values.
- R4: A state-register write issued while valid is 0 has no effect. This includes writes made during a software-reset window.
- R5: Code 2 (clear) leaves the state code unchanged. It raises core_flush for exactly one cycle, in the first cycle in which valid is back at 1.
- R6: A request that ends in state 0 (reset) raises core_flush for exactly one cycle, in the first cycle in which valid is back at 1. A run-to-pause request raises no flush.
- R7: The configuration register is at address 0. Its fields are: bits 4:0 word length minus one, bit 6 no-output, bit 7 no-input, and bits 11:8 mini-core select. All other bits read 0. Writes are accepted only while the state code is 0. In any other state a write is ignored and the register keeps its value.
- R8: Writing a word with bit 0 set to the software-reset register (address 2) returns the state code to 0 and clears the configuration word. From the next cycle, valid is held at 0 and core_flush at 1 for RST_SETTLE_CYCLES cycles, after which valid returns to 1. Writing a word with bit 0 clear has no effect, and the register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 configuration, 1 state, 2 software reset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| state_valid | output | 1 | High when no state transition or software reset is in progress |
| core_run | output | 1 | Core is in the run state |
| core_pause | output | 1 | Core is in the pause state (shifter frozen) |
| core_flush | output | 1 | Flush FIFOs and clear transfer counters and done flags |
| cfg_core_sel | output | 4 | Mini-core select |
| cfg_no_in | output | 1 | Input path disabled |
| cfg_no_out | output | 1 | Output path disabled |
| cfg_word_len | output | 5 | Word length minus one |

## Verification
The bench builds the controller with SETTLE_CYCLES = 3 and RST_SETTLE_CYCLES = 5, instead of the defaults of 2 and 8. This makes the two settling windows different in length and different from both defaults, so an off-by-one in either window, or a swap of the two, appears as a wrong valid or flush value in a specific cycle. The three-cycle state window leaves room for an ignored request in its first cycle while valid still has to stay low for two more. The short reset window keeps the complete software-reset sequence within a few cycles of monitored reads.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLEAR = 2'd2,
    ST_PAUSE = 2'd3
  } run_state_e;

  localparam int unsigned ADDR_CFG   = 0;
  localparam int unsigned ADDR_STATE = 1;
  localparam int unsigned ADDR_SWRST = 2;

  localparam int unsigned CFG_W     = 12;
  localparam logic [11:0] CFG_MASK  = 12'hFDF;

endpackage

// File: rtl/rsc_rst_sync.sv
module rsc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/rsc_settle_timer.sv
module rsc_settle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = len - CNT_W'(1);
      cnt_en = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/rsc_state_seq.sv
module rsc_state_seq
  import rsc_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES     = 2,
  parameter int unsigned RST_SETTLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       state_wr,
  input  logic [1:0] wcode,
  input  logic       swrst_wr,
  output logic       state_valid,
  output logic [1:0] state_code,
  output logic       flush,
  output logic       run,
  output logic       pause
);
  localparam int unsigned MAX_SETTLE =
    (SETTLE_CYCLES > RST_SETTLE_CYCLES) ? SETTLE_CYCLES : RST_SETTLE_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAX_SETTLE) + 1;

  run_state_e       state_q, state_d, target_q, target_d;
  logic             swb_q, swb_d;
  logic             flush_q, flush_d;
  logic             accept, tmr_start, tmr_busy, tmr_done;
  logic [CNT_W-1:0] tmr_len;

  assign accept    = state_wr && !tmr_busy;
  assign tmr_start = swrst_wr || accept;
  assign tmr_len   = swrst_wr ? CNT_W'(RST_SETTLE_CYCLES) : CNT_W'(SETTLE_CYCLES);

  rsc_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .len   (tmr_len),
    .busy  (tmr_busy),
    .done  (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    target_d = target_q;
    swb_d    = swb_q;
    flush_d  = 1'b0;
    if (swrst_wr) begin
      state_d  = ST_RESET;
      target_d = ST_RESET;
      swb_d    = 1'b1;
    end else if (accept) begin
      target_d = run_state_e'(wcode);
    end else if (tmr_done) begin
      swb_d = 1'b0;
      if (!swb_q) begin
        if (target_q != ST_CLEAR) state_d = target_q;
        flush_d = (target_q == ST_RESET) || (target_q == ST_CLEAR);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RESET;
      target_q <= ST_RESET;
      swb_q    <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      target_q <= target_d;
      swb_q    <= swb_d;
      flush_q  <= flush_d;
    end
  end

  assign state_valid = !tmr_busy;
  assign state_code  = state_q;
  assign flush       = flush_q || swb_q;
  assign run         = (state_q == ST_RUN);
  assign pause       = (state_q == ST_PAUSE);
endmodule

// File: rtl/rsc_cfg_reg.sv
module rsc_cfg_reg
  import rsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             in_reset,
  input  logic             swrst_wr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg
);
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cfg_en;

  always_comb begin
    cfg_en = 1'b0;
    cfg_d  = cfg_q;
    if (swrst_wr) begin
      cfg_en = 1'b1;
      cfg_d  = '0;
    end else if (wr && in_reset) begin
      cfg_en = 1'b1;
      cfg_d  = wdata & CFG_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/core_runstate_ctrl.sv
module core_runstate_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned DATA_W            = 32,
  parameter int unsigned ADDR_W            = 2,
  parameter int unsigned SETTLE_CYCLES     = 2,
  parameter int unsigned RST_SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              state_valid,
  output logic              core_run,
  output logic              core_pause,
  output logic              core_flush,
  output logic [3:0]        cfg_core_sel,
  output logic              cfg_no_in,
  output logic              cfg_no_out,
  output logic [4:0]        cfg_word_len
);
  logic             rst_core_n;
  logic             hit_cfg, hit_state, hit_swrst;
  logic             swrst_wr;
  logic [1:0]       state_code;
  logic [CFG_W-1:0] cfg_word;
  logic             unused_wdata;

  rsc_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  assign hit_cfg   = (reg_addr == ADDR_W'(ADDR_CFG));
  assign hit_state = (reg_addr == ADDR_W'(ADDR_STATE));
  assign hit_swrst = (reg_addr == ADDR_W'(ADDR_SWRST));
  assign swrst_wr  = reg_wr && hit_swrst && reg_wdata[0];
  assign unused_wdata = ^reg_wdata[DATA_W-1:CFG_W];

  rsc_state_seq #(
    .SETTLE_CYCLES     (SETTLE_CYCLES),
    .RST_SETTLE_CYCLES (RST_SETTLE_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .state_wr    (reg_wr && hit_state),
    .wcode       (reg_wdata[1:0]),
    .swrst_wr    (swrst_wr),
    .state_valid (state_valid),
    .state_code  (state_code),
    .flush       (core_flush),
    .run         (core_run),
    .pause       (core_pause)
  );

  rsc_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr       (reg_wr && hit_cfg),
    .in_reset (state_code == ST_RESET),
    .swrst_wr (swrst_wr),
    .wdata    (reg_wdata[CFG_W-1:0]),
    .cfg      (cfg_word)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_cfg)        reg_rdata[CFG_W-1:0] = cfg_word;
    else if (hit_state) reg_rdata[2:0]       = {state_valid, state_code};
  end

  assign cfg_word_len = cfg_word[4:0];
  assign cfg_no_out   = cfg_word[6];
  assign cfg_no_in    = cfg_word[7];
  assign cfg_core_sel = cfg_word[11:8];
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              state_valid,
  input logic              core_run,
  input logic              core_pause,
  input logic              core_flush,
  input logic [11:0]       cfg_word
);
  logic swrst_hit, state_hit;
  assign swrst_hit = reg_wr && (reg_addr == ADDR_W'(2)) && reg_wdata[0];
  assign state_hit = reg_wr && (reg_addr == ADDR_W'(1));

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_run && core_pause));

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_hit && state_valid) |=> !state_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_valid && !swrst_hit) |=>
      (state_valid || ($stable(core_run) && $stable(core_pause))));

  assert_cfg_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_run || core_pause) && !swrst_hit) |=> $stable(cfg_word));

  assert_swrst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_hit |=> (!state_valid && core_flush && !core_run && !core_pause
                   && (cfg_word == 12'h000)));
endmodule

bind core_runstate_ctrl rsc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .state_valid (state_valid),
  .core_run    (core_run),
  .core_pause  (core_pause),
  .core_flush  (core_flush),
  .cfg_word    (cfg_word)
);

// File: tb/tb_core_runstate_ctrl.sv
module tb_core_runstate_ctrl;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned A_CFG = 0, A_ST = 1, A_SW = 2;

  logic              clk, rst_n, reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;
  logic              state_valid, core_run, core_pause, core_flush;
  logic [3:0]        cfg_core_sel;
  logic              cfg_no_in, cfg_no_out;
  logic [4:0]        cfg_word_len;

  core_runstate_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .SETTLE_CYCLES(3), .RST_SETTLE_CYCLES(5)
  ) dut (.*);

  typedef struct { int req; logic [31:0] exp; } item_t;
  item_t sb_q[$];
  int checks = 0, errors = 0;
  bit done_flag = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] ob(input logic [11:0] cw, input logic f, p, r, v,
                                     input logic [11:0] rd);
    return {5'b0, cw[11:8], cw[7], cw[6], cw[4:0], f, p, r, v, rd};
  endfunction

  // monitor: pops one expected item per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = {5'b0, cfg_core_sel, cfg_no_in, cfg_no_out, cfg_word_len,
               core_flush, core_pause, core_run, state_valid, reg_rdata[11:0]};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL R%0d actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic step(input bit wr, input int addr, input logic [31:0] wd,
                      input int req, input logic [31:0] exp);
    item_t it;
    @(posedge clk); #1;
    reg_wr = wr; reg_addr = ADDR_W'(addr); reg_wdata = wd;
    it.req = req; it.exp = exp;
    sb_q.push_back(it);
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL R0 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] cw;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cw = 12'h000;
    // R1 reset state
    step(0, A_CFG, 0, 1, ob(cw, 0, 0, 0, 1, 12'h000));
    step(0, A_ST,  0, 1, ob(cw, 0, 0, 0, 1, 12'h004));
    // R7 config write in reset, masked
    step(1, A_CFG, 32'hABCD_31E7, 7, ob(cw, 0, 0, 0, 1, 12'h000));
    cw = 12'h1C7;
    step(0, A_CFG, 0, 7, ob(cw, 0, 0, 0, 1, cw));
    // R2 request run; R4 ignored write during window; R3 hold
    step(1, A_ST, 1, 2, ob(cw, 0, 0, 0, 1, 12'h004));
    step(1, A_ST, 3, 4, ob(cw, 0, 0, 0, 0, 12'h000));
    step(0, A_ST, 0, 3, ob(cw, 0, 0, 0, 0, 12'h000));
    step(0, A_ST, 0, 3, ob(cw, 0, 0, 0, 0, 12'h000));
    step(0, A_ST, 0, 2, ob(cw, 0, 0, 1, 1, 12'h005));
    // R7 config write ignored in run
    step(1, A_CFG, 32'h005, 7, ob(cw, 0, 0, 1, 1, cw));
    step(0, A_CFG, 0, 7, ob(cw, 0, 0, 1, 1, cw));
    // R6 run -> pause, no flush
    step(1, A_ST, 3, 2, ob(cw, 0, 0, 1, 1, 12'h005));
    for (int i = 0; i < 3; i++) step(0, A_ST, 0, 3, ob(cw, 0, 0, 1, 0, 12'h001));
    step(0, A_ST, 0, 6, ob(cw, 0, 1, 0, 1, 12'h007));
    // R5 clear from pause
    step(1, A_ST, 2, 5, ob(cw, 0, 1, 0, 1, 12'h007));
    for (int i = 0; i < 3; i++) step(0, A_ST, 0, 5, ob(cw, 0, 1, 0, 0, 12'h003));
    step(0, A_ST, 0, 5, ob(cw, 1, 1, 0, 1, 12'h007));
    step(0, A_ST, 0, 5, ob(cw, 0, 1, 0, 1, 12'h007));
    // R6 pause -> reset flush pulse
    step(1, A_ST, 0, 6, ob(cw, 0, 1, 0, 1, 12'h007));
    for (int i = 0; i < 3; i++) step(0, A_ST, 0, 6, ob(cw, 0, 1, 0, 0, 12'h003));
    step(0, A_ST, 0, 6, ob(cw, 1, 0, 0, 1, 12'h004));
    step(0, A_ST, 0, 6, ob(cw, 0, 0, 0, 1, 12'h004));
    // R7 new config accepted in reset
    step(1, A_CFG, 32'h20F, 7, ob(cw, 0, 0, 0, 1, cw));
    cw = 12'h20F;
    step(0, A_CFG, 0, 7, ob(cw, 0, 0, 0, 1, cw));
    // R8 software reset write with bit0 clear has no effect
    step(1, A_SW, 32'hFFFF_FFFE, 8, ob(cw, 0, 0, 0, 1, 12'h000));
    step(0, A_ST, 0, 8, ob(cw, 0, 0, 0, 1, 12'h004));
    step(0, A_CFG, 0, 8, ob(cw, 0, 0, 0, 1, cw));
    // go to run again
    step(1, A_ST, 1, 2, ob(cw, 0, 0, 0, 1, 12'h004));
    for (int i = 0; i < 3; i++) step(0, A_ST, 0, 3, ob(cw, 0, 0, 0, 0, 12'h000));
    step(0, A_ST, 0, 2, ob(cw, 0, 0, 1, 1, 12'h005));
    // R8 software reset from run; R4 state write during its window ignored
    step(1, A_SW, 1, 8, ob(cw, 0, 0, 1, 1, 12'h000));
    cw = 12'h000;
    step(1, A_ST, 1, 4, ob(cw, 1, 0, 0, 0, 12'h000));
    for (int i = 0; i < 4; i++) step(0, A_ST, 0, 8, ob(cw, 1, 0, 0, 0, 12'h000));
    step(0, A_ST, 0, 8, ob(cw, 0, 0, 0, 1, 12'h004));
    step(0, A_CFG, 0, 8, ob(cw, 0, 0, 0, 1, 12'h000));
    step(0, A_SW, 0, 8, ob(cw, 0, 0, 0, 1, 12'h000));
    @(posedge clk); #1 reg_wr = 1'b0;
    repeat (3) @(posedge clk);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule